// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers a set of level-sensitive interrupt lines, registers them once, and holds a per-line mask. The mask is never written as a whole word. Software changes it through two write-only ports on a simple word-wide register bus. One port masks every line whose bit is written as 1. The other port unmasks every line whose bit is written as 1. Software can read back the mask and the raw line levels. It can also read the winning line, which is the lowest-numbered line that is both active and unmasked. The winner is reported both as a one-hot word and as an index, and the index reads all ones when nothing is pending.

A single registered interrupt output tells the CPU that at least one unmasked line is active. In the default system, line 0 carries the timer, line 1 the keyboard and line 2 the network. The handler reads the index register, services that source, and reads again.

Register word offsets, in bytes:

| Offset | Access | Meaning |
|---|---|---|
| 0x00 | read | mask |
| 0x04 | write | mask-set |
| 0x08 | write | mask-clear |
| 0x0C | read | raw levels |
| 0x10 | read | one-hot winner |
| 0x14 | read | winner index |

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the mask is all ones, `cpu_irq` is 0 and `rd_data` is 0.
- R2: A read at offset 0x00 returns the mask, with bit i = 1 meaning line i is masked. A write to 0x00 leaves the mask unchanged.
- R3: A write to offset 0x04 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to offset 0x08 clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: A read at offset 0x0C returns the registered level of every line, whatever the mask. A line change is visible to a read issued on the edge after the one that samples it.
- R6: A read at offset 0x10 returns a word with exactly one bit set, for the winning line, or zero when no unmasked line is active.
- R7: A read at offset 0x14 returns the winning line's index, zero-extended, or 0xFFFFFFFF when no unmasked line is active.
- R8: Among active unmasked lines, the lowest index wins.
- R9: `cpu_irq` is high exactly when some sampled line is active and unmasked, one clock after the line sample. This is two rising edges after an input change.
- R10: Reads at any offset other than the four readable ones return zero. Writes at any offset other than 0x04 and 0x08 leave the mask unchanged.
- R11: `rd_data` is loaded on the rising edge at which `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| irq_in | input | NUM_LINES | level interrupt lines, 1 = active |
| wr_en | input | 1 | write strobe, one word per cycle |
| rd_en | input | 1 | read strobe |
| addr | input | ADDR_W | byte offset of the register |
| wr_data | input | DATA_W | write data |
| rd_data | output | DATA_W | registered read data |
| cpu_irq | output | 1 | registered combined interrupt to the CPU |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high together, and that `addr` and `wr_data` are stable for the whole cycle in which a strobe is high. The assertions also assume that `irq_in` is synchronous to `clk`. The stimulus changes every input only at the falling edge, and issues each bus access as a single strobe lasting one cycle. It never overlaps a read with a write. Line levels are changed only between bus accesses.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int OFS_MASK   = 'h00;
  localparam int OFS_SET    = 'h04;
  localparam int OFS_CLR    = 'h08;
  localparam int OFS_LEVEL  = 'h0C;
  localparam int OFS_ONEHOT = 'h10;
  localparam int OFS_INDEX  = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_LEVEL, SEL_ONEHOT, SEL_INDEX
  } rd_sel_e;
endpackage

// File: rtl/irqc_line_sampler.sv
`timescale 1ns/1ps
module irqc_line_sampler #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_in,
  output logic [NUM_LINES-1:0] lines_q
);
  always_ff @(posedge clk) begin
    if (rst) lines_q <= '0;
    else     lines_q <= lines_in;
  end
endmodule

// File: rtl/irqc_mask_reg.sv
`timescale 1ns/1ps
module irqc_mask_reg #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_we,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] bits,
  output logic [NUM_LINES-1:0] mask_q
);
  logic [NUM_LINES-1:0] set_v, clr_v;

  always_comb begin
    set_v = set_we ? bits : '0;
    clr_v = clr_we ? bits : '0;
  end

  // set is applied last so it dominates a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= (mask_q & ~clr_v) | set_v;
  end

  // R3: written ones become masked
  a_r3_set_masks: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask_q & $past(bits)) == $past(bits)));
  // R4: written ones become unmasked
  a_r4_clr_unmasks: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((mask_q & $past(bits)) == '0));
  // R3/R4: zero bits keep their value
  a_r3_zero_bits_keep: assert property (@(posedge clk) disable iff (rst)
    (set_we || clr_we) |=> ((mask_q & ~$past(bits)) == ($past(mask_q) & ~$past(bits))));
  // R10: no write strobe, no change
  a_r10_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/irqc_prio_pick.sv
`timescale 1ns/1ps
module irqc_prio_pick #(
  parameter int NUM_LINES = 32,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] onehot,
  output logic [IDX_W-1:0]     index,
  output logic                 any
);
  logic [NUM_LINES:0] lower_any;
  assign lower_any[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : g_chain
      assign onehot[gi]      = pending[gi] & ~lower_any[gi];
      assign lower_any[gi+1] = lower_any[gi] | pending[gi];
    end
  endgenerate

  assign any = lower_any[NUM_LINES];

  always_comb begin
    index = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (onehot[i]) index = index | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 cpu_irq
);
  import irqc_pkg::*;

  logic [NUM_LINES-1:0] lines_q, mask_q, pending, onehot;
  logic [IDX_W-1:0]     index;
  logic                 any;
  logic                 set_we, clr_we;
  rd_sel_e              rd_sel;
  logic [DATA_W-1:0]    rd_next;

  irqc_line_sampler #(.NUM_LINES(NUM_LINES)) u_sampler (
    .clk(clk), .rst(rst), .lines_in(irq_in), .lines_q(lines_q));

  assign set_we = wr_en && (addr == ADDR_W'(OFS_SET));
  assign clr_we = wr_en && (addr == ADDR_W'(OFS_CLR));

  irqc_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk(clk), .rst(rst), .set_we(set_we), .clr_we(clr_we),
    .bits(wr_data[NUM_LINES-1:0]), .mask_q(mask_q));

  assign pending = lines_q & ~mask_q;

  irqc_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .pending(pending), .onehot(onehot), .index(index), .any(any));

  always_comb begin
    unique case (addr)
      ADDR_W'(OFS_MASK):   rd_sel = SEL_MASK;
      ADDR_W'(OFS_LEVEL):  rd_sel = SEL_LEVEL;
      ADDR_W'(OFS_ONEHOT): rd_sel = SEL_ONEHOT;
      ADDR_W'(OFS_INDEX):  rd_sel = SEL_INDEX;
      default:             rd_sel = SEL_NONE;
    endcase
  end

  always_comb begin
    case (rd_sel)
      SEL_MASK:   rd_next = DATA_W'(mask_q);
      SEL_LEVEL:  rd_next = DATA_W'(lines_q);
      SEL_ONEHOT: rd_next = DATA_W'(onehot);
      SEL_INDEX:  rd_next = any ? DATA_W'(index) : '1;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      cpu_irq <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_next;
      cpu_irq <= any;
    end
  end

  // R6: at most one winner bit
  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(onehot));
  // R6/R8: winner is an active unmasked line
  a_r8_winner_pending: assert property (@(posedge clk) disable iff (rst)
    ((onehot & ~(lines_q & ~mask_q)) == '0));
  // R6: something pending implies a winner
  a_r6_no_miss: assert property (@(posedge clk) disable iff (rst)
    (pending != '0) |-> (onehot != '0));
  // R9: output follows the previous winner state
  a_r9_cpu_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpu_irq == ($past(onehot) != '0)));
  // R11: data holds without a read
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  // R10: undefined offsets read zero
  a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == SEL_NONE) |=> (rd_data == '0));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] irq_in;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        cpu_irq;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cpu_irq(cpu_irq));

  // {irq lines, unmask bits, expected one-hot, expected index}
  localparam logic [127:0] VEC [8] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 32'd0},
    {32'h0000_0006, 32'hFFFF_FFFF, 32'h0000_0002, 32'd1},
    {32'h0000_0006, 32'h0000_0004, 32'h0000_0004, 32'd2},
    {32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'd31},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'hF0F0_0000, 32'h00F0_0000, 32'h0010_0000, 32'd20},
    {32'hA000_0000, 32'hE000_0000, 32'h2000_0000, 32'd29}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic set_lines(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; irq_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 rd_data in reset", rd_data, 32'h0);
    check("R1 cpu_irq in reset", {31'b0, cpu_irq}, 32'h0);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 cpu_irq after reset", {31'b0, cpu_irq}, 32'h0);
    bus_read(8'h00, r); check("R1 mask all ones", r, 32'hFFFF_FFFF);

    // Vector table walk: R5 R6 R7 R8 R9 R2
    for (int k = 0; k < 8; k++) begin
      logic [31:0] lv, um, eo, ei;
      {lv, um, eo, ei} = VEC[k];
      bus_write(8'h04, 32'hFFFF_FFFF);
      bus_write(8'h08, um);
      set_lines(lv);
      bus_read(8'h10, r); check("R6 R8 one-hot winner", r, eo);
      bus_read(8'h14, r); check("R7 R8 winner index", r, ei);
      bus_read(8'h0C, r); check("R5 raw levels", r, lv);
      bus_read(8'h00, r); check("R2 mask readback", r, ~um);
      check("R9 cpu_irq level", {31'b0, cpu_irq}, {31'b0, (eo != 0)});
    end

    // R3: zero bits keep, ones set
    set_lines(32'h0);
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h04, 32'h0000_0010);
    bus_read(8'h00, r); check("R3 partial set", r, 32'h0000_0010);
    bus_write(8'h04, 32'h0000_0100);
    bus_read(8'h00, r); check("R3 set keeps others", r, 32'h0000_0110);
    // R4
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_write(8'h08, 32'h0000_0010);
    bus_read(8'h00, r); check("R4 partial clear", r, 32'hFFFF_FFEF);
    // R2 / R10: writes elsewhere ignored
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, r); check("R2 write to mask ignored", r, 32'hFFFF_FFEF);
    bus_write(8'h0C, 32'h0);
    bus_write(8'h20, 32'h0);
    bus_read(8'h00, r); check("R10 stray writes ignored", r, 32'hFFFF_FFEF);
    // R10: undefined reads
    bus_read(8'h18, r); check("R10 read 0x18", r, 32'h0);
    bus_read(8'h06, r); check("R10 read unaligned", r, 32'h0);
    bus_read(8'hFC, r); check("R10 read 0xFC", r, 32'h0);

    // R9: latency of two edges; line 4 is unmasked
    @(negedge clk); irq_in = 32'h0000_0010;
    @(posedge clk); #1;
    check("R9 not yet after one edge", {31'b0, cpu_irq}, 32'h0);
    @(posedge clk); #1;
    check("R9 high after two edges", {31'b0, cpu_irq}, 32'h1);
    // masked line does not raise it
    bus_write(8'h04, 32'h0000_0010);
    @(posedge clk); #1;
    check("R9 low once masked", {31'b0, cpu_irq}, 32'h0);

    // R11: hold without read
    bus_read(8'h0C, r); check("R11 read levels", r, 32'h0000_0010);
    set_lines(32'h0000_0003);
    repeat (2) @(posedge clk); #1;
    check("R11 rd_data holds", rd_data, 32'h0000_0010);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule